// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter with Timed or Released Tenure

This block decides which of several devices owns a shared bus. Every device request is merged onto one OR'ed request line, so the control logic only learns that somebody wants the bus, not who. When the bus is free and that line is active, the arbiter offers a grant at the head of a chain of per-device stages. A stage whose device is requesting keeps the grant and passes nothing on. A stage whose device is idle hands the grant to the next stage. The device closest to the head therefore wins any tie.

Ownership ends in one of two ways, chosen by `mode_async`. In timed mode (`mode_async` = 0) the owner keeps the bus for a fixed number of clock cycles, set by a parameter. While `halt` is high the count is frozen and no new owner is picked. In released mode (`mode_async` = 1) the owner keeps the bus until `release_i` is seen. Between two owners the grant always drops for at least one cycle. The owner is latched when the grant is issued. It is reported as a registered one-hot vector, together with a busy flag.

Top module: `chain_bus_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `head_grant`, `bus_busy` and every bit of `owner` are 0 after that edge.
- R2: If the bus is free and any bit of `dev_req` is 1 (and R7 does not block), `head_grant` and `bus_busy` go to 1 on the next clock edge. With all requests low, the grant stays 0.
- R3: Device index 0 is nearest the head of the chain. On a new grant, `owner` becomes one-hot on the lowest-index device that was requesting. `owner` never has more than one bit set.
- R4: A stage whose device is not requesting passes the grant on. Once granted, `owner` holds its value for the whole tenure, whatever `dev_req` does.
- R5: In timed mode with `halt` low, the grant lasts exactly `TENURE` cycles (default 4). The count starts again from zero at every new grant.
- R6: In timed mode, each cycle in which `halt` is high during a tenure freezes the count, which lengthens the tenure by one cycle.
- R7: In timed mode, `halt` high while the bus is free stops a new grant from starting, even if requests are pending.
- R8: In released mode, the grant is held until a cycle with `release_i` high. It drops on the next edge, and `halt` has no effect on it.
- R9: After any grant drops, `head_grant` stays 0 for at least one full cycle before the next owner is granted.
- R10: `release_i` has no effect in timed mode or while the bus is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_DEV | Per-device bus requests, merged onto one OR'ed line |
| mode_async | input | 1 | 0 = timed tenure, 1 = tenure ends on release |
| halt | input | 1 | Timed mode: freezes the tenure count and holds off new grants |
| release_i | input | 1 | Released mode: ends the current tenure |
| head_grant | output | 1 | Grant driven into the head of the chain (registered) |
| owner | output | N_DEV | One-hot current bus owner (registered) |
| bus_busy | output | 1 | Bus is currently owned (registered) |

## Verification
The bench aims at the following corner cases:
- **Simultaneous requests.** A chain that passed the grant past a requesting stage would name a farther device as owner, or two devices at once.
- **Halt during a tenure and halt while idle.** A counter that ignored the freeze would end the tenure early. A start path that ignored halt would hand out the bus while it should be held off.
- **Back-to-back owners.** This case exposes a missing one-cycle grant gap, or a counter that was not restarted at each new grant.
- **Mode mixing.** It catches release pulses acting in timed mode, halt acting in released mode, and a release arriving in the same cycle as a grant start.

// File: rtl/chain_arb_pkg.sv
package chain_arb_pkg;
  typedef enum logic {
    ST_FREE = 1'b0,
    ST_HELD = 1'b1
  } arb_state_t;
endpackage

// File: rtl/req_wired_or.sv
// Merges every device request into one line; identity of the requester is lost.
module req_wired_or #(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV-1:0] req,
  output logic             any_req
);
  logic [N_DEV:0] acc;
  assign acc[0] = 1'b0;
  generate
    for (genvar i = 0; i < N_DEV; i++) begin : g_or
      assign acc[i+1] = acc[i] | req[i];
    end
  endgenerate
  assign any_req = acc[N_DEV];
endmodule

// File: rtl/grant_stage.sv
// One link of the chain: keep the grant when requesting, otherwise forward it.
module grant_stage (
  input  logic grant_in,
  input  logic req,
  output logic take,
  output logic grant_out
);
  assign take      = grant_in & req;
  assign grant_out = grant_in & ~req;
endmodule

// File: rtl/tenure_timer.sv
// Counts tenure cycles; frozen when advance is low, cleared while the bus is free.
module tenure_timer #(
  parameter int TENURE = 4,
  parameter int CNT_W  = $clog2(TENURE) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  output logic expired
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TENURE - 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (advance && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt == LAST);
endmodule

// File: rtl/chain_bus_arbiter.sv
module chain_bus_arbiter
  import chain_arb_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int TENURE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DEV-1:0] dev_req,
  input  logic             mode_async,
  input  logic             halt,
  input  logic             release_i,
  output logic             head_grant,
  output logic [N_DEV-1:0] owner,
  output logic             bus_busy
);
  localparam int CNT_W = $clog2(TENURE) + 1;

  arb_state_t       state;
  logic             any_req;
  logic             start;
  logic             finish;
  logic             expired;
  logic [N_DEV-1:0] take_vec;
  logic [N_DEV-1:0] chain;

  req_wired_or #(.N_DEV(N_DEV)) u_or (
    .req     (dev_req),
    .any_req (any_req)
  );

  // Halt holds off the next arbitration only in timed mode.
  assign start = (state == ST_FREE) && any_req && !(halt && !mode_async);

  // Grant offered at the head of the chain when a new cycle starts.
  assign chain[0] = start;
  generate
    for (genvar i = 0; i < N_DEV; i++) begin : g_chain
      if (i < N_DEV - 1) begin : g_mid
        grant_stage u_stage (
          .grant_in  (chain[i]),
          .req       (dev_req[i]),
          .take      (take_vec[i]),
          .grant_out (chain[i+1])
        );
      end else begin : g_tail
        assign take_vec[i] = chain[i] & dev_req[i];
      end
    end
  endgenerate

  tenure_timer #(.TENURE(TENURE), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (state == ST_FREE),
    .advance ((state == ST_HELD) && !mode_async && !halt),
    .expired (expired)
  );

  always_comb begin
    finish = 1'b0;
    if (state == ST_HELD) begin
      if (mode_async) finish = release_i;
      else            finish = !halt && expired;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FREE;
      head_grant <= 1'b0;
      bus_busy   <= 1'b0;
      owner      <= '0;
    end else if (start) begin
      state      <= ST_HELD;
      head_grant <= 1'b1;
      bus_busy   <= 1'b1;
      owner      <= take_vec;
    end else if (finish) begin
      state      <= ST_FREE;
      head_grant <= 1'b0;
      bus_busy   <= 1'b0;
      owner      <= '0;
    end
  end
endmodule

// File: rtl/chain_arb_checker.sv
module chain_arb_checker #(
  parameter int N_DEV = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_DEV-1:0] dev_req,
  input logic             mode_async,
  input logic             halt,
  input logic             release_i,
  input logic             head_grant,
  input logic [N_DEV-1:0] owner,
  input logic             bus_busy
);
  assert_onehot_owner_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(owner));

  assert_busy_tracks_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_busy == head_grant) && (head_grant == (owner != '0)));

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(head_grant) |-> $past(dev_req) != '0);

  assert_owner_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (head_grant && $past(head_grant)) |-> $stable(owner));

  assert_halt_extends_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(head_grant) && !$past(mode_async) && $past(halt)) |-> head_grant);

  assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(head_grant) && !$past(mode_async) && $past(halt)) |-> !head_grant);

  assert_async_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(head_grant) && $past(mode_async) && !$past(release_i)) |-> head_grant);
endmodule

bind chain_bus_arbiter chain_arb_checker #(.N_DEV(N_DEV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dev_req    (dev_req),
  .mode_async (mode_async),
  .halt       (halt),
  .release_i  (release_i),
  .head_grant (head_grant),
  .owner      (owner),
  .bus_busy   (bus_busy)
);

// File: tb/tb_chain_bus_arbiter.sv
module tb_chain_bus_arbiter;
  localparam int N   = 4;
  localparam int TEN = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] req;
  logic         amode, halt, rel;
  logic         head_grant, bus_busy;
  logic [N-1:0] owner;

  int           compared   = 0;
  int           mismatched = 0;
  string        tag        = "R1";

  // behavioural reference state
  logic         m_grant;
  logic [N-1:0] m_owner;
  int           m_cnt;

  always #5 clk = ~clk;

  chain_bus_arbiter #(.N_DEV(N), .TENURE(TEN)) dut (
    .clk        (clk),
    .rst        (rst),
    .dev_req    (req),
    .mode_async (amode),
    .halt       (halt),
    .release_i  (rel),
    .head_grant (head_grant),
    .owner      (owner),
    .bus_busy   (bus_busy)
  );

  task automatic chk(input string r, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual %b expected %b", r, tag, $time, act, exp);
    end
  endtask

  function automatic logic [N-1:0] nearest(input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic model_next();
    if (rst) begin
      m_grant = 1'b0; m_owner = '0; m_cnt = 0;
    end else if (m_grant) begin
      if (amode) begin
        if (rel) begin m_grant = 1'b0; m_owner = '0; end            // R8
      end else if (!halt) begin                                     // R6
        if (m_cnt == TEN - 1) begin m_grant = 1'b0; m_owner = '0; end // R5
        else m_cnt++;
      end
    end else if (req != '0 && !(halt && !amode)) begin              // R2, R7
      m_grant = 1'b1; m_owner = nearest(req); m_cnt = 0;             // R3
    end
  endtask

  // compare outputs of the last edge, then apply inputs for the next edge
  task automatic step(input logic [N-1:0] r, input logic a, input logic h, input logic rl);
    @(negedge clk);
    chk({tag, " grant"}, N'(head_grant), N'(m_grant));
    chk({tag, " busy"},  N'(bus_busy),   N'(m_grant));
    chk({tag, " owner"}, owner,          m_owner);
    req = r; amode = a; halt = h; rel = rl;
    model_next();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1; req = '0; amode = 1'b0; halt = 1'b0; rel = 1'b0;
    m_grant = 1'b0; m_owner = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, with a request pending during reset
    tag = "R1";
    step(4'b1111, 1'b0, 1'b0, 1'b0);
    step(4'b0000, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R2/R5: single request, timed tenure of TEN cycles
    tag = "R5";
    step(4'b0100, 1'b0, 1'b0, 1'b0);
    repeat (7) step(4'b0000, 1'b0, 1'b0, 1'b0);

    // R3/R4: simultaneous requests, nearest wins; others keep asking
    tag = "R3";
    step(4'b1010, 1'b0, 1'b0, 1'b0);
    tag = "R4";
    repeat (5) step(4'b1011, 1'b0, 1'b0, 1'b0);
    // R9: back-to-back owners, one-cycle gap, counter restarts
    tag = "R9";
    repeat (10) step(4'b1001, 1'b0, 1'b0, 1'b0);
    step(4'b0000, 1'b0, 1'b0, 1'b0);
    repeat (4) step(4'b0000, 1'b0, 1'b0, 1'b0);

    // R6: halt during a timed tenure extends it
    tag = "R6";
    step(4'b1000, 1'b0, 1'b0, 1'b0);
    step(4'b0000, 1'b0, 1'b1, 1'b0);
    step(4'b0000, 1'b0, 1'b1, 1'b0);
    repeat (6) step(4'b0000, 1'b0, 1'b0, 1'b0);

    // R7: halt while free blocks the grant
    tag = "R7";
    repeat (3) step(4'b0010, 1'b0, 1'b1, 1'b0);
    repeat (6) step(4'b0010, 1'b0, 1'b0, 1'b0);
    repeat (3) step(4'b0000, 1'b0, 1'b0, 1'b0);

    // R10: release ignored in timed mode and while free
    tag = "R10";
    step(4'b0000, 1'b0, 1'b0, 1'b1);
    step(4'b0001, 1'b0, 1'b0, 1'b1);
    repeat (6) step(4'b0000, 1'b0, 1'b0, 1'b1);

    // R8: released mode holds until release; halt has no effect
    tag = "R8";
    step(4'b0110, 1'b1, 1'b1, 1'b0);
    repeat (8) step(4'b0000, 1'b1, 1'b1, 1'b0);
    step(4'b0001, 1'b1, 1'b0, 1'b1);
    step(4'b0001, 1'b1, 1'b0, 1'b0);
    repeat (3) step(4'b0000, 1'b1, 1'b0, 1'b0);
    step(4'b0000, 1'b1, 1'b0, 1'b1);
    repeat (2) step(4'b0000, 1'b1, 1'b0, 1'b0);

    // mixed random traffic over all modes
    tag = "R4 mix";
    begin
      logic a_mode;
      a_mode = 1'b0;
      for (int k = 0; k < 3000; k++) begin
        if ((k % 60) == 59) a_mode = ~a_mode;
        step(N'($urandom) & N'($urandom), a_mode,
             ($urandom % 6) == 0, ($urandom % 7) == 0);
      end
    end
    step(4'b0000, 1'b0, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule